// File: doc/BRIEF.md
# Three-Wire Sensor Link Master

This block drives a half-duplex serial link to a motion sensor over three wires: an active-low select, a clock that only the master drives, and one data line that both ends share. A host asks for an operation with a one-cycle start strobe. The operation can be a single register read, a single register write, a burst read of several bytes, or a bare select pulse that resynchronises the sensor's serial port. While the operation runs the block raises busy. Each received byte appears on the read-data port together with a one-cycle valid strobe.

The shared data pin is split into an output value, an output enable and an input. The enable is high only while the master shifts out a byte. All link timing is expressed in microseconds and converted to system clock cycles by the parameter `CLKS_PER_US`, written T below. The block does not interpret what the sensor returns. Bytes on the wire are most significant bit first.

Top module: `sns3w_master`

## Requirements
- R1: After reset, and whenever busy is low, select is high, the clock is high, the data output enable is low and the valid strobe is low.
- R2: Operation code 0 (read) sends the address byte with bit 7 clear, then clocks in one byte. That byte appears on the read-data port with a valid strobe that lasts one cycle.
- R3: Operation code 1 (write) sends the address byte with bit 7 set, then the write data byte. Both are sent most significant bit first, and no receive clocks follow.
- R4: Operation code 2 (burst) sends the address byte with bit 7 clear, then receives N bytes, each with its own valid strobe. A requested count of 0 gives N=1, a count above `MAX_BURST` gives N=`MAX_BURST`, and otherwise N equals the count.
- R5: For each transmitted bit, the clock is low for 2T cycles with the bit driven and held stable. The sensor latches the bit on the rising edge. Between bits of one byte the clock stays high for T cycles.
- R6: For each received bit, the output enable is low, the clock is low for T cycles, the line is sampled at the rising edge, and the clock stays high for T cycles.
- R7: After the last bit of every transmitted byte, the clock stays high with the output enable low for 5T cycles: T for the bit plus a 4T turnaround. Only then does the clock fall again or select rise.
- R8: After the last received byte, select rises exactly 2T cycles after the final rising clock edge.
- R9: Operation code 3 (resync) holds select low for exactly T cycles with no clock edge and no data drive.
- R10: A start strobe while busy is high has no effect on the operation in progress and starts nothing afterwards.
- R11: Each operation produces one continuous select-low period, and busy is high exactly while select is low. The period lasts 45T cycles for a read, 56T for a write, 29T+16T·N for a burst and T for a resync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request, taken only while idle |
| op_i | input | 2 | 0 read, 1 write, 2 burst, 3 resync |
| addr_i | input | 7 | Register address |
| wdata_i | input | 8 | Byte to write |
| count_i | input | CW | Burst length request (clamped to 1..MAX_BURST) |
| rdata_o | output | 8 | Last received byte |
| rvalid_o | output | 1 | One-cycle strobe per received byte |
| busy_o | output | 1 | Operation in progress |
| ncs_o | output | 1 | Active-low select |
| sclk_o | output | 1 | Serial clock, idles high |
| sdio_o | output | 1 | Data value driven when enabled |
| sdio_oe_o | output | 1 | Data pin output enable |
| sdio_i | input | 1 | Data value read from the pin |

## Verification
A sensor model in the bench captures every transmitted bit on rising clock edges. On each receive falling edge it drives bytes from a random response list. The four operation codes are mixed at random with random addresses, write data and burst counts from 0 to 15, so both clamp boundaries and in-range lengths are covered. Directed cases cover counts 0, 1, 8 and 12, a resync, and start strobes injected in the middle of reads, writes and bursts. Exact clock-phase widths, turnaround and tail lengths, and the total select-low length separate errors in shift order, in direction handling and in each timing constant.

// File: rtl/sns3w_pkg.sv
package sns3w_pkg;

    typedef enum logic [1:0] {
        OP_RD    = 2'd0,
        OP_WR    = 2'd1,
        OP_BURST = 2'd2,
        OP_SYNC  = 2'd3
    } sns_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_TXLO,
        S_TXHI,
        S_GAP,
        S_RXLO,
        S_RXHI,
        S_TAIL,
        S_PULSE
    } sns_state_e;

    // Number of bytes a burst really returns for a requested count
    function automatic int unsigned burst_len(input int unsigned req, input int unsigned maxb);
        if (req == 0)
            return 1;
        else if (req > maxb)
            return maxb;
        else
            return req;
    endfunction

endpackage

// File: rtl/sns3w_timer.sv
module sns3w_timer #(
    parameter int unsigned TW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          done
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - TW'(1);
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/sns3w_shift.sv
module sns3w_shift (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [7:0] load_byte,
    input  logic       adv,
    input  logic       in_bit,
    output logic [7:0] q,
    output logic       last
);
    logic [2:0] bitc;

    always_ff @(posedge clk) begin
        if (rst) begin
            q    <= '0;
            bitc <= 3'd7;
        end else if (load) begin
            q    <= load_byte;
            bitc <= 3'd7;
        end else if (adv) begin
            q    <= {q[6:0], in_bit};
            bitc <= bitc - 3'd1;
        end
    end

    assign last = (bitc == 3'd0);
endmodule

// File: rtl/sns3w_master.sv
module sns3w_master
    import sns3w_pkg::*;
#(
    parameter int unsigned CLKS_PER_US = 4,
    parameter int unsigned MAX_BURST   = 8,
    parameter int unsigned CW          = $clog2(MAX_BURST + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic [1:0]    op_i,
    input  logic [6:0]    addr_i,
    input  logic [7:0]    wdata_i,
    input  logic [CW-1:0] count_i,
    output logic [7:0]    rdata_o,
    output logic          rvalid_o,
    output logic          busy_o,
    output logic          ncs_o,
    output logic          sclk_o,
    output logic          sdio_o,
    output logic          sdio_oe_o,
    input  logic          sdio_i
);
    localparam int unsigned TW = $clog2(4 * CLKS_PER_US + 1);
    localparam int unsigned NW = $clog2(MAX_BURST + 1);
    localparam logic [TW-1:0] T1 = TW'(CLKS_PER_US - 1);
    localparam logic [TW-1:0] T2 = TW'(2 * CLKS_PER_US - 1);
    localparam logic [TW-1:0] T4 = TW'(4 * CLKS_PER_US - 1);

    sns_state_e    state;
    sns_op_e       op_q;
    logic [7:0]    wdata_q;
    logic [NW-1:0] nleft;
    logic          wr_ph;

    logic          tload, tdone;
    logic [TW-1:0] tval;
    logic          sh_load, sh_adv, sh_in, sh_last;
    logic [7:0]    sh_byte, sh_q;

    sns3w_timer #(.TW(TW)) u_tmr (
        .clk(clk), .rst(rst), .load(tload), .load_val(tval), .done(tdone)
    );

    sns3w_shift u_sh (
        .clk(clk), .rst(rst), .load(sh_load), .load_byte(sh_byte),
        .adv(sh_adv), .in_bit(sh_in), .q(sh_q), .last(sh_last)
    );

    assign sdio_o = sh_q[7];
    assign busy_o = (state != S_IDLE);

    // Timer and shifter control
    always_comb begin
        tload   = 1'b0;
        tval    = '0;
        sh_load = 1'b0;
        sh_byte = '0;
        sh_adv  = 1'b0;
        sh_in   = 1'b0;
        case (state)
            S_IDLE: if (start_i) begin
                tload   = 1'b1;
                sh_load = 1'b1;
                case (sns_op_e'(op_i))
                    OP_SYNC: tval = T1;
                    OP_WR: begin
                        tval    = T2;
                        sh_byte = {1'b1, addr_i};
                    end
                    default: begin
                        tval    = T2;
                        sh_byte = {1'b0, addr_i};
                    end
                endcase
            end
            S_TXLO: if (tdone) begin
                tload = 1'b1;
                tval  = T1;
            end
            S_TXHI: if (tdone) begin
                tload = 1'b1;
                if (!sh_last) begin
                    sh_adv = 1'b1;
                    tval   = T2;
                end else begin
                    tval = T4;
                end
            end
            S_GAP: if (tdone && !(op_q == OP_WR && wr_ph)) begin
                tload   = 1'b1;
                sh_load = 1'b1;
                if (op_q == OP_WR) begin
                    sh_byte = wdata_q;
                    tval    = T2;
                end else begin
                    tval = T1;
                end
            end
            S_RXLO: if (tdone) begin
                tload  = 1'b1;
                tval   = T1;
                sh_adv = 1'b1;
                sh_in  = sdio_i;
            end
            S_RXHI: if (tdone) begin
                tload = 1'b1;
                tval  = T1;
            end
            default: ;
        endcase
    end

    // Sequencer and pin registers
    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            op_q      <= OP_RD;
            wdata_q   <= '0;
            nleft     <= '0;
            wr_ph     <= 1'b0;
            ncs_o     <= 1'b1;
            sclk_o    <= 1'b1;
            sdio_oe_o <= 1'b0;
            rdata_o   <= '0;
            rvalid_o  <= 1'b0;
        end else begin
            rvalid_o <= 1'b0;
            case (state)
                S_IDLE: if (start_i) begin
                    op_q    <= sns_op_e'(op_i);
                    wdata_q <= wdata_i;
                    wr_ph   <= 1'b0;
                    ncs_o   <= 1'b0;
                    nleft   <= (sns_op_e'(op_i) == OP_BURST)
                               ? NW'(burst_len(32'(count_i), MAX_BURST)) : NW'(1);
                    if (sns_op_e'(op_i) == OP_SYNC) begin
                        state <= S_PULSE;
                    end else begin
                        state     <= S_TXLO;
                        sclk_o    <= 1'b0;
                        sdio_oe_o <= 1'b1;
                    end
                end
                S_TXLO: if (tdone) begin
                    sclk_o <= 1'b1;
                    state  <= S_TXHI;
                end
                S_TXHI: if (tdone) begin
                    if (!sh_last) begin
                        sclk_o <= 1'b0;
                        state  <= S_TXLO;
                    end else begin
                        sdio_oe_o <= 1'b0;
                        state     <= S_GAP;
                    end
                end
                S_GAP: if (tdone) begin
                    if (op_q == OP_WR) begin
                        if (wr_ph) begin
                            ncs_o <= 1'b1;
                            state <= S_IDLE;
                        end else begin
                            wr_ph     <= 1'b1;
                            sclk_o    <= 1'b0;
                            sdio_oe_o <= 1'b1;
                            state     <= S_TXLO;
                        end
                    end else begin
                        sclk_o <= 1'b0;
                        state  <= S_RXLO;
                    end
                end
                S_RXLO: if (tdone) begin
                    sclk_o <= 1'b1;
                    state  <= S_RXHI;
                    if (sh_last) begin
                        rvalid_o <= 1'b1;
                        rdata_o  <= {sh_q[6:0], sdio_i};
                        nleft    <= nleft - NW'(1);
                    end
                end
                S_RXHI: if (tdone) begin
                    if (nleft == '0) begin
                        state <= S_TAIL;
                    end else begin
                        sclk_o <= 1'b0;
                        state  <= S_RXLO;
                    end
                end
                S_TAIL, S_PULSE: if (tdone) begin
                    ncs_o <= 1'b1;
                    state <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sns3w_chk.sv
module sns3w_chk (
    input logic clk,
    input logic rst,
    input logic busy_o,
    input logic ncs_o,
    input logic sclk_o,
    input logic sdio_o,
    input logic sdio_oe_o,
    input logic rvalid_o
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (ncs_o && sclk_o && !sdio_oe_o && !rvalid_o));

    // R11
    sel_busy_chk: assert property (@(posedge clk) disable iff (rst)
        !ncs_o |-> busy_o);

    // R11
    end_sel_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> $rose(ncs_o));

    // R5
    tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sdio_oe_o && $past(sdio_oe_o) && !$fell(sclk_o)) |-> $stable(sdio_o));

    // R6
    rx_release_chk: assert property (@(posedge clk) disable iff (rst)
        rvalid_o |-> !sdio_oe_o);

    // R2
    rvalid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rvalid_o |=> !rvalid_o);
endmodule

bind sns3w_master sns3w_chk u_chk (
    .clk(clk), .rst(rst), .busy_o(busy_o), .ncs_o(ncs_o), .sclk_o(sclk_o),
    .sdio_o(sdio_o), .sdio_oe_o(sdio_oe_o), .rvalid_o(rvalid_o)
);

// File: tb/sim_sns3w_master.sv
module sim_sns3w_master;
    localparam int CLK_PERIOD = 10;
    localparam int T    = 4;
    localparam int MAXB = 8;
    localparam int CW   = $clog2(MAXB + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0;
    logic [1:0] op_i = 2'd0;
    logic [6:0] addr_i = '0;
    logic [7:0] wdata_i = '0;
    logic [CW-1:0] count_i = '0;
    logic sdio_i;
    logic [7:0] rdata_o;
    logic rvalid_o, busy_o, ncs_o, sclk_o, sdio_o, sdio_oe_o;

    sns3w_master #(.CLKS_PER_US(T), .MAX_BURST(MAXB)) u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .count_i(count_i), .rdata_o(rdata_o), .rvalid_o(rvalid_o),
        .busy_o(busy_o), .ncs_o(ncs_o), .sclk_o(sclk_o), .sdio_o(sdio_o),
        .sdio_oe_o(sdio_oe_o), .sdio_i(sdio_i)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int errors = 0;
    int checks = 0;

    // sensor model and link monitor state
    int cyc = 0;
    bit p_sclk, p_ncs, rise_tx, fall_oe, any_rise;
    int last_fall, last_rise, ncs_start, txbits, rxbits, nedges, ncs_falls = 0;
    int terr, gerr, ncs_len, end_hi, ntx, nrx, hi;
    logic [7:0] txcap;
    logic [7:0] txb [2];
    logic [7:0] rxg [8];
    logic [7:0] resp [8];

    always @(negedge clk) begin
        cyc++;
        if (rst) begin
            sdio_i <= 1'b1;
            p_sclk = 1'b1;
            p_ncs  = 1'b1;
        end else begin
            if (p_ncs && !ncs_o) begin
                ncs_falls++;
                ncs_start = cyc;
                any_rise = 0; txbits = 0; rxbits = 0; nedges = 0;
                terr = 0; gerr = 0; ntx = 0; nrx = 0; rise_tx = 0;
            end
            if (rvalid_o && nrx < 8) begin
                rxg[nrx] = rdata_o;
                nrx++;
            end
            if (!p_sclk && sclk_o) begin
                nedges++;
                if (cyc - last_fall != (fall_oe ? 2*T : T)) terr++;
                if (sdio_oe_o) begin
                    txcap = {txcap[6:0], sdio_o};
                    txbits++;
                    if (txbits % 8 == 0 && ntx < 2) begin
                        txb[ntx] = txcap;
                        ntx++;
                    end
                end
                last_rise = cyc;
                rise_tx   = sdio_oe_o;
                any_rise  = 1;
            end
            if (p_sclk && !sclk_o) begin
                nedges++;
                if (any_rise) begin
                    hi = cyc - last_rise;
                    if (rise_tx && txbits % 8 == 0) begin
                        if (hi != 5*T) gerr++;
                    end else if (hi != T) terr++;
                end
                last_fall = cyc;
                fall_oe   = sdio_oe_o;
                if (!sdio_oe_o) begin
                    sdio_i <= resp[(rxbits/8) % 8][7 - (rxbits % 8)];
                    rxbits++;
                end
            end
            if (!p_ncs && ncs_o) begin
                ncs_len = cyc - ncs_start;
                end_hi  = any_rise ? cyc - last_rise : -1;
            end
            p_sclk = sclk_o;
            p_ncs  = ncs_o;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_bytes(input int op, input int cnt);
        if (op == 0) return 1;
        if (op == 2) return (cnt == 0) ? 1 : ((cnt > MAXB) ? MAXB : cnt);
        return 0;
    endfunction

    function automatic int exp_len(input int op, input int n);
        case (op)
            0, 2:    return 29*T + 16*T*n;
            1:       return 56*T;
            default: return T;
        endcase
    endfunction

    task automatic run(input int op, input int addr, input int wd, input int cnt, input bit inject);
        int falls0, n, bad;
        for (int i = 0; i < 8; i++) resp[i] = 8'($urandom);
        falls0 = ncs_falls;
        @(negedge clk);
        op_i = 2'(op); addr_i = 7'(addr); wdata_i = 8'(wd); count_i = CW'(cnt);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (inject) begin
            repeat (5*T) @(negedge clk);
            op_i = 2'(op ^ 1); addr_i = ~7'(addr); wdata_i = ~8'(wd);
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        while (busy_o) @(negedge clk);
        repeat (12) @(negedge clk);
        #1;
        n = exp_bytes(op, cnt);
        // R10 R11: exactly one select period
        check(ncs_falls - falls0 == 1, inject ? "R10" : "R11", ncs_falls - falls0, 1);
        check(ncs_len == exp_len(op, n), inject ? "R10" : "R11", ncs_len, exp_len(op, n));
        if (op == 3) begin
            check(nedges == 0, "R9", nedges, 0);
            check(ncs_len == T, "R9", ncs_len, T);
            return;
        end
        if (op == 1) begin
            check(ntx == 2, "R3", ntx, 2);
            check(txb[0] == {1'b1, 7'(addr)}, "R3", txb[0], {1'b1, 7'(addr)});
            check(txb[1] == 8'(wd), "R3", txb[1], wd);
            check(nrx == 0 && rxbits == 0, "R3", rxbits, 0);
            check(end_hi == 5*T, "R7", end_hi, 5*T);
        end else begin
            check(ntx == 1, op == 0 ? "R2" : "R4", ntx, 1);
            check(txb[0] == {1'b0, 7'(addr)}, op == 0 ? "R2" : "R4", txb[0], {1'b0, 7'(addr)});
            check(nrx == n, op == 0 ? "R2" : "R4", nrx, n);
            bad = 0;
            for (int i = 0; i < n && i < 8; i++) if (rxg[i] !== resp[i]) bad++;
            check(bad == 0, op == 0 ? "R2" : "R4", bad, 0);
            check(end_hi == 2*T, "R8", end_hi, 2*T);
        end
        check(terr == 0, "R5/R6", terr, 0);
        check(gerr == 0, "R7", gerr, 0);
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        // R1 reset state
        check(ncs_o == 1'b1, "R1", ncs_o, 1);
        check(sclk_o == 1'b1, "R1", sclk_o, 1);
        check(sdio_oe_o == 1'b0, "R1", sdio_oe_o, 0);
        check(busy_o == 1'b0 && rvalid_o == 1'b0, "R1", busy_o, 0);

        run(0, 7'h02, 0, 0, 0);      // R2 read
        run(1, 7'h19, 8'hA5, 0, 0);  // R3 write
        run(2, 7'h63, 0, 1, 0);      // R4 burst of 1
        run(2, 7'h63, 0, 0, 0);      // R4 count 0 -> 1
        run(2, 7'h63, 0, 8, 0);      // R4 max
        run(2, 7'h63, 0, 12, 0);     // R4 clamp above max
        run(2, 7'h63, 0, 5, 0);      // R4 mid
        run(3, 0, 0, 0, 0);          // R9 resync
        run(0, 7'h7F, 0, 0, 1);      // R10 during read
        run(1, 7'h00, 8'h01, 0, 1);  // R10 during write
        run(2, 7'h11, 0, 3, 1);      // R10 during burst

        for (int k = 0; k < 30; k++) begin
            int op;
            op = int'($urandom % 4);
            run(op, int'($urandom % 128), int'($urandom % 256), int'($urandom % 16),
                (op != 3) && ($urandom % 3 == 0));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule